// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block drives a pipelined analog-to-digital converter through programmed conversion sequences. Each of several sequencers holds a list of up to sixteen channel slots. When its selected start trigger fires, the sequencer sends one sample request per slot to the converter, one request per cycle. The request carries the channel number and a tag that names the sequencer. Results come back later on a valid strobe carrying the same tag. The controller stores each result in that sequencer's result register and raises per-sequencer status flags for end of conversion, end of sequence and overrun.

What happens at the end of a sequence depends on configuration. A sequencer can stop until software acknowledges the end-of-sequence flag. It can instead re-arm itself for the next trigger. Sequencer 0 alone can run free: it begins the next pass as soon as its last slot has been issued, without draining the converter pipeline. Outside free-running operation, the end-of-sequence flag waits for a pipeline-flush delay that is computed from the resolution and sample-hold settings.

Software clears flags by writing ones to a status-clear strobe. It marks a result as consumed with a per-sequencer read strobe. The converter itself and interrupt routing lie outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every sequencer is idle, conv_req is 0 and every bit of sts_eoc, sts_eos and sts_ovr is 0.
- R2: An idle sequencer s starts when trig_src[cfg_trgsel field s] is 1 at a clock edge. The cycle after that edge it begins issuing requests: one per cycle while granted, for slots 0 to L, where L is its 4-bit cfg_len field (L+1 slots). Each request drives conv_chan = cfg_chans[(s*16+k)*4 +: 4] for slot k, and conv_tag = s.
- R3: A cycle with conv_valid = 1 and conv_vtag = s sets sts_eoc[s] and loads conv_data into res_data[s*DW +: DW].
- R4: sts_ovr[s] sets when sequencer s starts a sequence while its result register holds a value that has not been read since its last update.
- R5: A trigger that arrives while sequencer s is issuing or flushing starts nothing and issues no extra request.
- R6: Outside free-running operation, sts_eos[s] rises exactly F+1 cycles after the edge that retires the last request, where F = max(0, cfg_sres/2 + 3 - cfg_shd). With the trigger at edge E0, this is edge E0+L+F+2.
- R7: With cfg_sa[s] = 0, a finished sequencer ignores triggers until a status-clear write carries 1 in clr_eos[s]. That write clears sts_eos[s] and re-arms the sequencer.
- R8: With cfg_sa[s] = 1, a finished sequencer re-arms by itself, and the next trigger starts a new sequence with no acknowledge.
- R9: With cfg_frm = 1, sequencer 0 issues slot 0 of the next pass in the cycle after its last slot and sets sts_eos[0] at that same edge, with no flush wait. Triggers of the other sequencers start nothing while cfg_frm = 1.
- R10: A cycle with clr_we = 1 clears each flag whose clr_eoc, clr_eos or clr_ovr bit is 1 and leaves flags with a 0 bit unchanged. A flag set in the same cycle stays 1.
- R11: When several sequencers request in the same cycle, the lowest-numbered one is granted and the others wait.
- R12: A cycle with rd_stb[s] = 1 marks the result of sequencer s as read, so a later start raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_src | input | NTRIG | Start trigger sources |
| cfg_frm | input | 1 | Free-running enable for sequencer 0 |
| cfg_sres | input | SRESW | Resolution setting used in flush length |
| cfg_shd | input | SHDW | Sample-hold delay used in flush length |
| cfg_len | input | NSEQ*SLOTW | Per-sequencer last slot index |
| cfg_chans | input | NSEQ*16*CHW | Per-sequencer slot channel lists |
| cfg_sa | input | NSEQ | Per-sequencer auto re-arm (1) or wait for acknowledge (0) |
| cfg_trgsel | input | NSEQ*TSELW | Per-sequencer trigger source select |
| clr_we | input | 1 | Status-clear write strobe |
| clr_eoc | input | NSEQ | Clear mask for end-of-conversion flags |
| clr_eos | input | NSEQ | Clear mask and acknowledge for end-of-sequence flags |
| clr_ovr | input | NSEQ | Clear mask for overrun flags |
| rd_stb | input | NSEQ | Per-sequencer result read strobe |
| conv_req | output | 1 | Sample request to converter |
| conv_chan | output | CHW | Channel of current request |
| conv_tag | output | TAGW | Sequencer that owns the request |
| conv_valid | input | 1 | Converter result valid |
| conv_vtag | input | TAGW | Owner tag of the returned result |
| conv_data | input | DW | Returned conversion value |
| res_data | output | NSEQ*DW | Per-sequencer result registers |
| sts_eoc | output | NSEQ | End-of-conversion flags |
| sts_eos | output | NSEQ | End-of-sequence flags |
| sts_ovr | output | NSEQ | Overrun flags |

## Verification
Assertions check several properties on every cycle. At most one sequencer is granted, and a lower-numbered requester always wins. A waiting sequencer stays waiting until acknowledged. An end-of-sequence flag outside free-running operation can only come out of the flush state, a flushing sequencer never re-enters issue, an overrun only rises over an unread result, and every tagged result raises its end-of-conversion flag. The bench scenarios show the rest: the exact slot and channel order, the flush delay at a long and a zero setting, ignored triggers, the acknowledge release, auto re-arm, the free-running restart and its hand-back, set-over-clear, and clearing overrun through a read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    // Drain wait after the last request, clamped at zero.
    function automatic int flush_cycles(input int sres, input int shd);
        int v;
        v = sres / 2 + 3 - shd;
        return (v < 0) ? 0 : v;
    endfunction

endpackage

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic found;

    always_comb begin
        grant = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                idx      = IW'(i);
                found    = 1'b1;
            end
        end
    end

    assign any = |req;

    // R11: never more than one grant
    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11: grants only go to requesters
    a_r11_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R11: lowest index wins
    a_r11_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> grant[0]);

endmodule

// File: rtl/adc_seq_unit.sv
module adc_seq_unit
    import adc_seq_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int NTRIG = 4,
    parameter int TSELW = 2,
    parameter int SLOTW = 4,
    parameter int CHW   = 4,
    parameter int DW    = 12,
    parameter int CNTW  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NTRIG-1:0]              trig_src,
    input  logic [TSELW-1:0]              trgsel,
    input  logic [SLOTW-1:0]              len,
    input  logic [(1<<SLOTW)*CHW-1:0]     chans,
    input  logic                          sa,
    input  logic                          frm,
    input  logic [CNTW-1:0]               flush_n,
    input  logic                          grant,
    input  logic                          clr_we,
    input  logic                          clr_eoc,
    input  logic                          clr_eos,
    input  logic                          clr_ovr,
    input  logic                          rd_stb,
    input  logic                          res_valid,
    input  logic [DW-1:0]                 res_in,
    output logic                          want,
    output logic [CHW-1:0]                chan,
    output logic                          eoc,
    output logic                          eos,
    output logic                          ovr,
    output logic [DW-1:0]                 res
);

    typedef struct packed {
        seq_state_e       st;
        logic [SLOTW-1:0] slot;
        logic [CNTW-1:0]  cnt;
        logic             eoc;
        logic             eos;
        logic             ovr;
        logic             unread;
        logic [DW-1:0]    res;
    } unit_t;

    unit_t q, d;
    logic  frm_eff;
    logic  blocked;
    logic  trig;
    logic  start;
    logic  eos_set;

    // Free-running capability exists only in sequencer 0.
    generate
        if (IDX == 0) begin : g_free_run
            assign frm_eff = frm;
            assign blocked = 1'b0;
        end else begin : g_plain
            assign frm_eff = 1'b0;
            assign blocked = frm;
        end
    endgenerate

    assign trig = trig_src[trgsel];

    always_comb begin
        d       = q;
        start   = 1'b0;
        eos_set = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (trig && !blocked) begin
                    d.st   = ST_RUN;
                    d.slot = '0;
                    start  = 1'b1;
                end
            end
            ST_RUN: begin
                if (grant) begin
                    if (q.slot == len) begin
                        if (frm_eff) begin
                            d.slot  = '0;
                            start   = 1'b1;
                            eos_set = 1'b1;
                        end else begin
                            d.st  = ST_FLUSH;
                            d.cnt = flush_n;
                        end
                    end else begin
                        d.slot = q.slot + 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (q.cnt == '0) begin
                    eos_set = 1'b1;
                    d.st    = sa ? ST_IDLE : ST_HOLD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (clr_we && clr_eos) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // Clears first, sets afterwards so a set in the same cycle wins.
        if (clr_we) begin
            if (clr_eoc) d.eoc = 1'b0;
            if (clr_eos) d.eos = 1'b0;
            if (clr_ovr) d.ovr = 1'b0;
        end
        if (start && q.unread) d.ovr = 1'b1;
        if (eos_set)           d.eos = 1'b1;

        if (res_valid) begin
            d.eoc    = 1'b1;
            d.res    = res_in;
            d.unread = 1'b1;
        end else if (rd_stb) begin
            d.unread = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign want = (q.st == ST_RUN);
    assign chan = chans[q.slot*CHW +: CHW];
    assign eoc  = q.eoc;
    assign eos  = q.eos;
    assign ovr  = q.ovr;
    assign res  = q.res;

    // R7: a waiting sequencer stays put until acknowledged
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD && !(clr_we && clr_eos)) |=> (q.st == ST_HOLD));

    // R4: overrun rises only over an unread result
    a_r4_ovr_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.unread));

    // R6: outside free running, end of sequence only leaves the flush state
    a_r6_eos_from_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.eos) && !$past(frm_eff)) |-> ($past(q.st) == ST_FLUSH));

    // R5: a flushing sequencer never goes straight back to issuing
    a_r5_flush_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FLUSH) |=> (q.st != ST_RUN));

    // R3: each accepted result raises end of conversion
    a_r3_eoc_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> q.eoc);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NSEQ  = 2,
    parameter int NTRIG = 4,
    parameter int SLOTW = 4,
    parameter int CHW   = 4,
    parameter int DW    = 12,
    parameter int SRESW = 5,
    parameter int SHDW  = 4,
    parameter int TSELW = $clog2(NTRIG),
    parameter int TAGW  = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NTRIG-1:0]                trig_src,
    input  logic                            cfg_frm,
    input  logic [SRESW-1:0]                cfg_sres,
    input  logic [SHDW-1:0]                 cfg_shd,
    input  logic [NSEQ*SLOTW-1:0]           cfg_len,
    input  logic [NSEQ*(1<<SLOTW)*CHW-1:0]  cfg_chans,
    input  logic [NSEQ-1:0]                 cfg_sa,
    input  logic [NSEQ*TSELW-1:0]           cfg_trgsel,
    input  logic                            clr_we,
    input  logic [NSEQ-1:0]                 clr_eoc,
    input  logic [NSEQ-1:0]                 clr_eos,
    input  logic [NSEQ-1:0]                 clr_ovr,
    input  logic [NSEQ-1:0]                 rd_stb,
    output logic                            conv_req,
    output logic [CHW-1:0]                  conv_chan,
    output logic [TAGW-1:0]                 conv_tag,
    input  logic                            conv_valid,
    input  logic [TAGW-1:0]                 conv_vtag,
    input  logic [DW-1:0]                   conv_data,
    output logic [NSEQ*DW-1:0]              res_data,
    output logic [NSEQ-1:0]                 sts_eoc,
    output logic [NSEQ-1:0]                 sts_eos,
    output logic [NSEQ-1:0]                 sts_ovr
);

    localparam int NSLOT = 1 << SLOTW;
    localparam int LISTW = NSLOT * CHW;
    localparam int CNTW  = SRESW + 1;

    logic [CNTW-1:0] flush_n;
    logic [NSEQ-1:0] want;
    logic [NSEQ-1:0] grant;
    logic [NSEQ-1:0] vsel;
    logic [TAGW-1:0] gidx;
    logic [CHW-1:0]  uchan [NSEQ];

    assign flush_n = CNTW'(flush_cycles(int'(cfg_sres), int'(cfg_shd)));

    adc_seq_arb #(
        .N  (NSEQ),
        .IW (TAGW)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (want),
        .grant (grant),
        .any   (conv_req),
        .idx   (gidx)
    );

    generate
        for (genvar g = 0; g < NSEQ; g++) begin : g_seq
            assign vsel[g] = conv_valid && (conv_vtag == TAGW'(g));

            adc_seq_unit #(
                .IDX   (g),
                .NTRIG (NTRIG),
                .TSELW (TSELW),
                .SLOTW (SLOTW),
                .CHW   (CHW),
                .DW    (DW),
                .CNTW  (CNTW)
            ) u_seq (
                .clk       (clk),
                .rst_n     (rst_n),
                .trig_src  (trig_src),
                .trgsel    (cfg_trgsel[g*TSELW +: TSELW]),
                .len       (cfg_len[g*SLOTW +: SLOTW]),
                .chans     (cfg_chans[g*LISTW +: LISTW]),
                .sa        (cfg_sa[g]),
                .frm       (cfg_frm),
                .flush_n   (flush_n),
                .grant     (grant[g]),
                .clr_we    (clr_we),
                .clr_eoc   (clr_eoc[g]),
                .clr_eos   (clr_eos[g]),
                .clr_ovr   (clr_ovr[g]),
                .rd_stb    (rd_stb[g]),
                .res_valid (vsel[g]),
                .res_in    (conv_data),
                .want      (want[g]),
                .chan      (uchan[g]),
                .eoc       (sts_eoc[g]),
                .eos       (sts_eos[g]),
                .ovr       (sts_ovr[g]),
                .res       (res_data[g*DW +: DW])
            );
        end
    endgenerate

    assign conv_chan = uchan[gidx];
    assign conv_tag  = gidx;

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

    localparam int NSEQ = 2, NTRIG = 4, SLOTW = 4, CHW = 4, DW = 12;
    localparam int SRESW = 5, SHDW = 4, TSELW = 2, TAGW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NTRIG-1:0] trig_src = '0;
    logic cfg_frm = 1'b0;
    logic [SRESW-1:0] cfg_sres = 5'd12;
    logic [SHDW-1:0] cfg_shd = 4'd1;
    logic [NSEQ*SLOTW-1:0] cfg_len = '0;
    logic [NSEQ*16*CHW-1:0] cfg_chans = '0;
    logic [NSEQ-1:0] cfg_sa = '0;
    logic [NSEQ*TSELW-1:0] cfg_trgsel = '0;
    logic clr_we = 1'b0;
    logic [NSEQ-1:0] clr_eoc = '0, clr_eos = '0, clr_ovr = '0, rd_stb = '0;
    logic conv_req;
    logic [CHW-1:0] conv_chan;
    logic [TAGW-1:0] conv_tag;
    logic conv_valid;
    logic [TAGW-1:0] conv_vtag;
    logic [DW-1:0] conv_data;
    logic [NSEQ*DW-1:0] res_data;
    logic [NSEQ-1:0] sts_eoc, sts_eos, sts_ovr;

    int n_checks = 0, n_fail = 0, n_unexp = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_src(trig_src), .cfg_frm(cfg_frm),
        .cfg_sres(cfg_sres), .cfg_shd(cfg_shd), .cfg_len(cfg_len),
        .cfg_chans(cfg_chans), .cfg_sa(cfg_sa), .cfg_trgsel(cfg_trgsel),
        .clr_we(clr_we), .clr_eoc(clr_eoc), .clr_eos(clr_eos), .clr_ovr(clr_ovr),
        .rd_stb(rd_stb), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_tag(conv_tag), .conv_valid(conv_valid), .conv_vtag(conv_vtag),
        .conv_data(conv_data), .res_data(res_data), .sts_eoc(sts_eoc),
        .sts_eos(sts_eos), .sts_ovr(sts_ovr)
    );

    // Converter model: three-stage pipeline echoing tag and channel.
    logic v1 = 0, v2 = 0, v3 = 0;
    logic [TAGW-1:0] t1 = 0, t2 = 0, t3 = 0;
    logic [CHW-1:0] c1 = 0, c2 = 0, c3 = 0;
    always @(posedge clk) begin
        v1 <= conv_req; t1 <= conv_tag; c1 <= conv_chan;
        v2 <= v1; t2 <= t1; c2 <= c1;
        v3 <= v2; t3 <= t2; c3 <= c2;
    end
    assign conv_valid = v3;
    assign conv_vtag  = t3;
    assign conv_data  = {4'(t3), c3, 4'hA};

    function automatic int ch(input int s, input int k);
        return (s == 0) ? ((k * 3 + 1) % 16) : (15 - k);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic expect_seq(input int s, input int last);
        for (int k = 0; k <= last; k++) exp_q.push_back(s * 16 + ch(s, k));
    endtask

    task automatic pulse_trig(input logic [NTRIG-1:0] m);
        @(negedge clk); trig_src = m;
        @(negedge clk); trig_src = '0;
    endtask

    task automatic clr_write(input logic [NSEQ-1:0] e, input logic [NSEQ-1:0] s,
                             input logic [NSEQ-1:0] o);
        @(negedge clk); clr_we = 1'b1; clr_eoc = e; clr_eos = s; clr_ovr = o;
        @(negedge clk); clr_we = 1'b0; clr_eoc = '0; clr_eos = '0; clr_ovr = '0;
    endtask

    task automatic read_res(input logic [NSEQ-1:0] m);
        @(negedge clk); rd_stb = m;
        @(negedge clk); rd_stb = '0;
    endtask

    // Scoreboard monitor: every request must match the next expected item.
    always begin
        @(posedge clk); #1;
        if (rst_n && conv_req) begin
            if (exp_q.size() == 0) begin
                n_unexp++;
                chk(1'b0, "R5 unexpected request", int'({conv_tag, conv_chan}), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'({conv_tag, conv_chan}) == e, "R2 request order",
                    int'({conv_tag, conv_chan}), e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 50000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSEQ; s++)
            for (int k = 0; k < 16; k++)
                cfg_chans[(s*16+k)*4 +: 4] = 4'(ch(s, k));
        cfg_len[3:0] = 4'd3; cfg_len[7:4] = 4'd0;
        cfg_trgsel[1:0] = 2'd0; cfg_trgsel[3:2] = 2'd1;
        cfg_sa = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick;
        // R1 reset state
        chk(conv_req == 1'b0, "R1 conv_req", int'(conv_req), 0);
        chk({sts_eoc, sts_eos, sts_ovr} == '0, "R1 flags",
            int'({sts_eoc, sts_eos, sts_ovr}), 0);

        // R6 flush wait F = 12/2+3-1 = 8, L = 3
        expect_seq(0, 3);
        pulse_trig(4'b0001);
        repeat (12) tick;
        chk(sts_eos[0] == 1'b0, "R6 eos early", int'(sts_eos[0]), 0);
        tick;
        chk(sts_eos[0] == 1'b1, "R6 eos on time", int'(sts_eos[0]), 1);
        repeat (6) tick;
        chk(sts_eoc[0] == 1'b1, "R3 eoc", int'(sts_eoc[0]), 1);
        chk(res_data[11:0] == {4'd0, 4'(ch(0, 3)), 4'hA}, "R3 result",
            int'(res_data[11:0]), int'({4'd0, 4'(ch(0, 3)), 4'hA}));
        chk(sts_ovr[0] == 1'b0, "R4 no overrun first", int'(sts_ovr[0]), 0);

        // R7 trigger ignored while waiting for acknowledge
        pulse_trig(4'b0001);
        repeat (10) tick;
        chk(n_unexp == 0 && sts_eos[0], "R7 held", n_unexp, 0);
        clr_write(2'b00, 2'b01, 2'b00);
        tick;
        chk(sts_eos[0] == 1'b0, "R10 eos cleared", int'(sts_eos[0]), 0);
        chk(sts_eoc[0] == 1'b1, "R10 eoc untouched", int'(sts_eoc[0]), 1);
        expect_seq(0, 3);
        pulse_trig(4'b0001);
        repeat (13) tick;
        chk(sts_eos[0] == 1'b1, "R7 released", int'(sts_eos[0]), 1);
        chk(sts_ovr[0] == 1'b1, "R4 overrun", int'(sts_ovr[0]), 1);

        // R5 trigger during issue ignored; R12 read prevents overrun
        @(negedge clk); cfg_sa[0] = 1'b1;
        repeat (4) tick;
        clr_write(2'b01, 2'b01, 2'b01);
        read_res(2'b01);
        expect_seq(0, 3);
        pulse_trig(4'b0001);
        pulse_trig(4'b0001);
        repeat (14) tick;
        chk(exp_q.size() == 0 && n_unexp == 0, "R5 busy trigger", n_unexp, 0);
        chk(sts_ovr[0] == 1'b0, "R12 no overrun after read", int'(sts_ovr[0]), 0);

        // Sequencer 1, F = 8/2+3-7 = 0, L = 0
        @(negedge clk); cfg_sres = 5'd8; cfg_shd = 4'd7;
        expect_seq(1, 0);
        pulse_trig(4'b0010);
        tick;
        chk(sts_eos[1] == 1'b0, "R6 zero flush early", int'(sts_eos[1]), 0);
        tick;
        chk(sts_eos[1] == 1'b1, "R6 zero flush on time", int'(sts_eos[1]), 1);
        repeat (5) tick;
        expect_seq(1, 0);
        pulse_trig(4'b0010);
        repeat (6) tick;
        chk(exp_q.size() == 0 && n_unexp == 0, "R8 auto rearm", exp_q.size(), 0);
        chk(sts_ovr[1] == 1'b1, "R4 overrun seq1", int'(sts_ovr[1]), 1);
        clr_write(2'b10, 2'b10, 2'b10);
        read_res(2'b10);
        expect_seq(1, 0);
        pulse_trig(4'b0010);
        tick;
        @(negedge clk); clr_we = 1'b1; clr_eos = 2'b10;
        tick;
        chk(sts_eos[1] == 1'b1, "R10 set wins", int'(sts_eos[1]), 1);
        @(negedge clk); clr_we = 1'b0; clr_eos = '0;
        repeat (5) tick;
        chk(sts_ovr[1] == 1'b0, "R12 seq1 no overrun", int'(sts_ovr[1]), 0);

        // R11 simultaneous start: sequencer 0 first
        clr_write(2'b11, 2'b11, 2'b11);
        @(negedge clk); cfg_len[3:0] = 4'd1; cfg_len[7:4] = 4'd1;
        expect_seq(0, 1);
        expect_seq(1, 1);
        pulse_trig(4'b0011);
        repeat (12) tick;
        chk(exp_q.size() == 0 && n_unexp == 0, "R11 priority", exp_q.size(), 0);
        chk(res_data[23:12] == {4'd1, 4'(ch(1, 1)), 4'hA}, "R3 result seq1",
            int'(res_data[23:12]), int'({4'd1, 4'(ch(1, 1)), 4'hA}));

        // R9 free running on sequencer 0, L = 2
        clr_write(2'b11, 2'b11, 2'b11);
        @(negedge clk); cfg_len[3:0] = 4'd2; cfg_frm = 1'b1;
        expect_seq(0, 2); expect_seq(0, 2); expect_seq(0, 2);
        pulse_trig(4'b0011);
        for (int t = 1; t <= 6; t++) begin
            tick;
            if (t == 2) chk(sts_eos[0] == 1'b0, "R9 eos before last", int'(sts_eos[0]), 0);
            if (t == 3) chk(sts_eos[0] == 1'b1, "R9 eos no flush", int'(sts_eos[0]), 1);
            if (t == 3) chk(conv_req == 1'b1, "R9 immediate restart", int'(conv_req), 1);
        end
        chk(conv_req == 1'b1, "R9 third pass", int'(conv_req), 1);
        @(negedge clk); cfg_frm = 1'b0;
        repeat (12) tick;
        chk(exp_q.size() == 0 && n_unexp == 0, "R9 pass count", exp_q.size(), 0);
        chk(sts_eos[1] == 1'b0, "R9 seq1 blocked", int'(sts_eos[1]), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule